// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block combines two eight-input priority units into one vectored interrupt controller. The secondary unit is chained into input 2 of the primary unit, so the processor sees a single interrupt output fed by fifteen usable request lines. Each cycle the block registers the enabled request levels and compares the best pending line against the levels already in service. It raises `int_o` whenever a pending request outranks every level in service.

The processor answers with a one-cycle acknowledge. The block then records the winning line as in service and presents an 8-bit vector on the following cycle. The vector is a per-unit programmable 5-bit base followed by the 3-bit index of the line within its unit. A one-cycle end-of-interrupt pulse retires the most important level in service.

Legacy requests on input bit 2 are folded onto line 9 of the secondary unit, because input 2 of the primary unit is taken by the cascade link.

Top module: `pic_cascade`

## Requirements
- R1: After reset, `int_o` and `vec_vld_o` are low, `vec_o` is zero and no level is in service.
- R2: Each cycle, request bit i is registered as pending if `irq_i[i]` is high and `mask_i[i]` is low. `int_o` reflects that register one cycle after the sample. A masked line never raises `int_o`.
- R3: Lines rank, from most to least important: 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7. An acknowledge picks the most important pending line.
- R4: The cycle after `ack_i`, `vec_vld_o` is high for one cycle. For lines 8..15 `vec_o` is `{base_s_i, line-8}`, and for lines 0, 1 and 3..7 it is `{base_m_i, line[2:0]}`. `vec_o` keeps its value until the next acknowledge.
- R5: A line in service blocks `int_o` for requests of equal or lower rank. A more important request raises `int_o`, including one secondary line pre-empting another.
- R6: An `eoi_i` pulse retires the most important level in service. The primary unit's cascade level stays in service until the secondary unit has no level left.
- R7: `irq_i[2]` acts as a request on line 9. `mask_i[9]` gates it and `mask_i[2]` has no effect.
- R8: An acknowledge while `int_o` is low returns `{base_m_i, 3'b111}` and puts no level in service.
- R9: When `ack_i` and `eoi_i` arrive in the same cycle, both act on the state from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 16 | Request levels, one per line; bit 2 is the legacy line folded onto 9 |
| mask_i | input | 16 | Per-line disable, 1 = masked |
| base_m_i | input | 5 | Vector base for the primary unit |
| base_s_i | input | 5 | Vector base for the secondary unit |
| ack_i | input | 1 | One-cycle processor acknowledge |
| eoi_i | input | 1 | One-cycle end-of-interrupt |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector of the last acknowledge |
| vec_vld_o | output | 1 | High the cycle after an acknowledge |

## Verification
The bench nests one secondary line inside another and retires the inner one. It then raises line 3 and checks that it stays blocked. A design that cleared the cascade level on every retire would let that lower request through early.

It drops a request before the acknowledge and expects the spurious vector. A design that latched requests permanently would return the stale line instead, and would also leave a level in service.

It drives the legacy bit 2 under both masks, since a missing remap produces a cascade-numbered vector or no interrupt at all. Long random runs mix acknowledges and retires in the same cycle to expose any ordering mismatch between the two units.

// File: rtl/pic_pkg.sv
package pic_pkg;
   // Source of the vector delivered on an acknowledge
   typedef enum logic [1:0] {
      VK_SPURIOUS = 2'd0,
      VK_MASTER   = 2'd1,
      VK_SLAVE    = 2'd2
   } vec_kind_e;
endpackage

// File: rtl/pic_line_latch.sv
module pic_line_latch #(
   parameter int TOTAL      = 16,
   parameter int CASCADE_IN = 2,
   parameter int REMAP_LINE = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TOTAL-1:0] irq_i,
   input  logic [TOTAL-1:0] mask_i,
   output logic [TOTAL-1:0] lines_q
);
   logic [TOTAL-1:0] eff;

   for (genvar i = 0; i < TOTAL; i++) begin : g_line
      if (i == CASCADE_IN) begin : g_link
         // input consumed by the cascade link
         assign eff[i] = 1'b0;
      end else if (i == REMAP_LINE) begin : g_remap
         assign eff[i] = (irq_i[i] | irq_i[CASCADE_IN]) & ~mask_i[i];
      end else begin : g_plain
         assign eff[i] = irq_i[i] & ~mask_i[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lines_q <= '0;
      else        lines_q <= eff;
   end

   // mask bit of the link line has no function
   logic unused_mask;
   assign unused_mask = mask_i[CASCADE_IN];
endmodule

// File: rtl/pic_prio_unit.sv
module pic_prio_unit #(
   parameter int N        = 8,
   parameter int PASS_IDX = -1,   // input allowed to nest on its own level
   localparam int IW      = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          take,
   input  logic          retire,
   output logic          hit,
   output logic [IW-1:0] win,
   output logic [N-1:0]  isr
);
   logic [N-1:0]  isr_q, set_v, clr_v;
   logic [IW-1:0] top;
   logic          any_req, top_any, nest_ok;

   if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_n
      $error("pic_prio_unit: N must be a power of two >= 2");
   end

   always_comb begin
      win = '0;
      for (int i = N - 1; i >= 0; i--) if (req[i]) win = IW'(i);
      top = '0;
      for (int i = N - 1; i >= 0; i--) if (isr_q[i]) top = IW'(i);
   end

   assign any_req = |req;
   assign top_any = |isr_q;

   if (PASS_IDX >= 0) begin : g_pass
      assign nest_ok = top_any && (win == IW'(PASS_IDX)) && (top == IW'(PASS_IDX));
   end else begin : g_nopass
      assign nest_ok = 1'b0;
   end

   assign hit   = any_req && (!top_any || (win < top) || nest_ok);
   assign set_v = (take && hit)        ? ({{(N-1){1'b0}}, 1'b1} << win) : '0;
   assign clr_v = (retire && top_any)  ? ({{(N-1){1'b0}}, 1'b1} << top) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= (isr_q & ~clr_v) | set_v;
   end

   assign isr = isr_q;
endmodule

// File: rtl/pic_vec_gen.sv
module pic_vec_gen #(
   parameter int IW = 3,
   parameter int BW = 5,
   localparam int VW = IW + BW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ack,
   input  pic_pkg::vec_kind_e kind,
   input  logic [BW-1:0]     base_m,
   input  logic [BW-1:0]     base_s,
   input  logic [IW-1:0]     m_win,
   input  logic [IW-1:0]     s_win,
   output logic [VW-1:0]     vec_o,
   output logic              vld_o
);
   import pic_pkg::*;
   localparam logic [IW-1:0] LOW_IDX = '1;
   logic [VW-1:0] vec_d;

   always_comb begin
      unique case (kind)
         VK_SLAVE:  vec_d = {base_s, s_win};
         VK_MASTER: vec_d = {base_m, m_win};
         default:   vec_d = {base_m, LOW_IDX};
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_o <= '0;
         vld_o <= 1'b0;
      end else begin
         vld_o <= ack;
         if (ack) vec_o <= vec_d;
      end
   end
endmodule

// File: rtl/pic_cascade.sv
module pic_cascade #(
   parameter int UNIT_LINES      = 8,
   parameter int CASCADE_IN      = 2,
   parameter int REMAP_SLAVE_IDX = 1,
   parameter int VEC_W           = 8,
   localparam int IW    = $clog2(UNIT_LINES),
   localparam int BW    = VEC_W - IW,
   localparam int TOTAL = 2 * UNIT_LINES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TOTAL-1:0] irq_i,
   input  logic [TOTAL-1:0] mask_i,
   input  logic [BW-1:0]    base_m_i,
   input  logic [BW-1:0]    base_s_i,
   input  logic             ack_i,
   input  logic             eoi_i,
   output logic             int_o,
   output logic [VEC_W-1:0] vec_o,
   output logic             vec_vld_o
);
   import pic_pkg::*;
   localparam int REMAP_LINE = UNIT_LINES + REMAP_SLAVE_IDX;
   localparam logic [UNIT_LINES-1:0] ABOVE_CAS = UNIT_LINES'((1 << CASCADE_IN) - 1);

   if (CASCADE_IN < 0 || CASCADE_IN >= UNIT_LINES) begin : g_bad_cas
      $error("pic_cascade: CASCADE_IN out of range");
   end
   if (REMAP_SLAVE_IDX < 0 || REMAP_SLAVE_IDX >= UNIT_LINES) begin : g_bad_remap
      $error("pic_cascade: REMAP_SLAVE_IDX out of range");
   end
   if (BW < 1) begin : g_bad_vec
      $error("pic_cascade: VEC_W too small for the line index");
   end

   logic [TOTAL-1:0]      lines_q;
   logic [UNIT_LINES-1:0] m_req, s_req, m_isr, s_isr;
   logic                  m_hit, s_hit, m_take, s_take, m_retire, s_retire;
   logic [IW-1:0]         m_win, s_win;
   logic                  m_top_cas, s_multi;
   vec_kind_e             kind;

   pic_line_latch #(.TOTAL(TOTAL), .CASCADE_IN(CASCADE_IN), .REMAP_LINE(REMAP_LINE))
      u_latch (.clk(clk), .rst_n(rst_n), .irq_i(irq_i), .mask_i(mask_i), .lines_q(lines_q));

   assign s_req = lines_q[TOTAL-1:UNIT_LINES];

   for (genvar k = 0; k < UNIT_LINES; k++) begin : g_mreq
      if (k == CASCADE_IN) begin : g_link
         assign m_req[k] = s_hit | lines_q[k];
      end else begin : g_direct
         assign m_req[k] = lines_q[k];
      end
   end

   // cascade level is the primary's most important in-service level
   assign m_top_cas = m_isr[CASCADE_IN] && ((m_isr & ABOVE_CAS) == '0);
   assign s_multi   = (s_isr & (s_isr - 1'b1)) != '0;

   assign m_take   = ack_i;
   assign s_take   = ack_i && m_hit && (m_win == IW'(CASCADE_IN));
   assign m_retire = eoi_i && !(m_top_cas && s_multi);
   assign s_retire = eoi_i && m_top_cas;

   pic_prio_unit #(.N(UNIT_LINES), .PASS_IDX(CASCADE_IN)) u_master (
      .clk(clk), .rst_n(rst_n), .req(m_req), .take(m_take), .retire(m_retire),
      .hit(m_hit), .win(m_win), .isr(m_isr));

   pic_prio_unit #(.N(UNIT_LINES), .PASS_IDX(-1)) u_slave (
      .clk(clk), .rst_n(rst_n), .req(s_req), .take(s_take), .retire(s_retire),
      .hit(s_hit), .win(s_win), .isr(s_isr));

   always_comb begin
      if (!m_hit)                          kind = VK_SPURIOUS;
      else if (m_win == IW'(CASCADE_IN))   kind = VK_SLAVE;
      else                                 kind = VK_MASTER;
   end

   pic_vec_gen #(.IW(IW), .BW(BW)) u_vec (
      .clk(clk), .rst_n(rst_n), .ack(ack_i), .kind(kind),
      .base_m(base_m_i), .base_s(base_s_i), .m_win(m_win), .s_win(s_win),
      .vec_o(vec_o), .vld_o(vec_vld_o));

   assign int_o = m_hit;
endmodule

// File: rtl/pic_cascade_chk.sv
module pic_cascade_chk #(
   parameter int UNIT_LINES = 8,
   parameter int CASCADE_IN = 2,
   parameter int VEC_W      = 8,
   localparam int IW    = $clog2(UNIT_LINES),
   localparam int BW    = VEC_W - IW,
   localparam int TOTAL = 2 * UNIT_LINES
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [TOTAL-1:0]      irq_i,
   input logic [BW-1:0]         base_m_i,
   input logic                  ack_i,
   input logic                  int_o,
   input logic [VEC_W-1:0]      vec_o,
   input logic                  vec_vld_o,
   input logic [UNIT_LINES-1:0] m_isr,
   input logic [UNIT_LINES-1:0] s_isr
);
   localparam logic [IW-1:0] LOW_IDX = '1;

   AST_ACK_GIVES_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |=> vec_vld_o);                                           // R4
   AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_i |=> !vec_vld_o);                                         // R4
   AST_SPURIOUS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !int_o) |=> (vec_o == {$past(base_m_i), LOW_IDX}));   // R8
   AST_INT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      int_o |-> ($past(irq_i) != '0));                                // R2
   AST_CASCADE_TRACKS_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
      m_isr[CASCADE_IN] == (s_isr != '0));                            // R6
endmodule

bind pic_cascade pic_cascade_chk #(
   .UNIT_LINES(UNIT_LINES), .CASCADE_IN(CASCADE_IN), .VEC_W(VEC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .base_m_i(base_m_i), .ack_i(ack_i),
   .int_o(int_o), .vec_o(vec_o), .vec_vld_o(vec_vld_o), .m_isr(m_isr), .s_isr(s_isr));

// File: tb/tb_pic_cascade.sv
module tb_pic_cascade;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq = '0, mask = '0;
   logic [4:0]  base_m = 5'h08, base_s = 5'h10;
   logic        ack = 1'b0, eoi = 1'b0;
   logic        int_o, vec_vld_o;
   logic [7:0]  vec_o;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   pic_cascade dut (
      .clk(clk), .rst_n(rst_n), .irq_i(irq), .mask_i(mask),
      .base_m_i(base_m), .base_s_i(base_s), .ack_i(ack), .eoi_i(eoi),
      .int_o(int_o), .vec_o(vec_o), .vec_vld_o(vec_vld_o));

   always #2 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   bit [15:0] m_lines, m_isr;
   bit        m_vld, m_int;
   int        m_vec;

   function automatic int rank(input int l);
      if (l < 2)  return l;
      if (l >= 8) return l - 6;
      return l + 7;
   endfunction

   function automatic int best_of(input bit [15:0] s);
      int b = -1;
      for (int l = 0; l < 16; l++)
         if (s[l] && (b < 0 || rank(l) < rank(b))) b = l;
      return b;
   endfunction

   function automatic bit hit_of(input bit [15:0] ln, input bit [15:0] is);
      int p = best_of(ln);
      int t = best_of(is);
      return (p >= 0) && (t < 0 || rank(p) < rank(t));
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_lines = '0; m_isr = '0; m_vld = 0; m_vec = 0; m_int = 0;
      end else begin
         int p, t;
         bit h;
         bit [15:0] e;
         p = best_of(m_lines);
         t = best_of(m_isr);
         h = hit_of(m_lines, m_isr);
         if (eoi && t >= 0) m_isr[t] = 1'b0;          // R6 / R9: pre-edge top
         m_vld = ack;
         if (ack) begin
            if (h) begin
               m_isr[p] = 1'b1;
               m_vec = (p >= 8) ? ((int'(base_s) << 3) | (p - 8))
                                : ((int'(base_m) << 3) | p);
            end else begin
               m_vec = (int'(base_m) << 3) | 7;    // R8
            end
         end
         for (int l = 0; l < 16; l++) e[l] = irq[l] & ~mask[l];
         e[9] = e[9] | (irq[2] & ~mask[9]);         // R7
         e[2] = 1'b0;
         m_lines = e;
         m_int = hit_of(m_lines, m_isr);
      end
      #1;
      if (rst_n && !done) begin
         chk(int_o == m_int, "R5 model int_o", int_o, m_int);
         chk(vec_vld_o == m_vld, "R4 model vec_vld_o", vec_vld_o, m_vld);
         chk(vec_o == m_vec[7:0], "R3 model vec_o", vec_o, m_vec[7:0]);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_ack(input logic [7:0] exp, input string tag);
      ack = 1'b1; @(negedge clk); ack = 1'b0;
      chk(vec_vld_o === 1'b1, tag, vec_vld_o, 1);
      chk(vec_o === exp, tag, vec_o, exp);
   endtask

   task automatic do_eoi();
      eoi = 1'b1; @(negedge clk); eoi = 1'b0;
   endtask

   initial begin : watchdog
      #(200000 * 4);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      step(3);
      // R1: reset state
      chk(int_o === 1'b0, "R1 int_o", int_o, 0);
      chk(vec_vld_o === 1'b0, "R1 vec_vld_o", vec_vld_o, 0);
      chk(vec_o === 8'h00, "R1 vec_o", vec_o, 0);
      rst_n = 1'b1;
      step(2);

      // R2 / R4: single master line
      irq[5] = 1'b1; step(1);
      chk(int_o === 1'b1, "R2 int after latch", int_o, 1);
      do_ack(8'h45, "R4 vector line 5");
      chk(int_o === 1'b0, "R5 same level blocked", int_o, 0);
      irq = '0; do_eoi(); step(1);

      // R2: masked line stays silent
      mask[4] = 1'b1; irq[4] = 1'b1; step(2);
      chk(int_o === 1'b0, "R2 masked line", int_o, 0);
      irq = '0; mask = '0; step(1);

      // R3 / R5: order and pre-emption
      irq[3] = 1'b1; irq[12] = 1'b1; irq[7] = 1'b1; step(1);
      chk(int_o === 1'b1, "R3 int with three lines", int_o, 1);
      do_ack(8'h84, "R3 slave 12 beats 3 and 7");
      chk(int_o === 1'b0, "R5 lower lines wait", int_o, 0);
      irq[1] = 1'b1; step(1);
      chk(int_o === 1'b1, "R5 line 1 pre-empts", int_o, 1);
      do_ack(8'h41, "R3 line 1 vector");
      irq[1] = 1'b0; irq[12] = 1'b0; do_eoi(); do_eoi(); step(1);
      chk(int_o === 1'b1, "R6 levels retired", int_o, 1);
      do_ack(8'h43, "R3 line 3 before 7");
      irq = '0; do_eoi(); step(1);

      // R6: nested secondary lines keep the cascade level
      irq[12] = 1'b1; step(1);
      do_ack(8'h84, "R6 slave 12");
      irq[8] = 1'b1; step(1);
      chk(int_o === 1'b1, "R5 slave 8 pre-empts 12", int_o, 1);
      do_ack(8'h80, "R6 slave 8");
      irq[8] = 1'b0; do_eoi();
      irq[3] = 1'b1; irq[13] = 1'b1; step(1);
      chk(int_o === 1'b0, "R6 cascade level kept", int_o, 0);
      irq[12] = 1'b0; do_eoi(); step(1);
      chk(int_o === 1'b1, "R6 cascade level cleared", int_o, 1);
      do_ack(8'h85, "R6 slave 13 before 3");
      irq = '0; do_eoi(); step(1);

      // R7: legacy line folded to 9
      mask[2] = 1'b1; irq[2] = 1'b1; step(1);
      chk(int_o === 1'b1, "R7 line 2 ignores mask bit 2", int_o, 1);
      do_ack(8'h81, "R7 line 2 delivered as 9");
      irq = '0; do_eoi();
      mask = 16'h0200; irq[2] = 1'b1; step(2);
      chk(int_o === 1'b0, "R7 mask bit 9 gates line 2", int_o, 0);
      irq = '0; mask = '0; step(1);

      // R8: dropped request gives spurious vector
      irq[6] = 1'b1; step(1);
      chk(int_o === 1'b1, "R8 request seen", int_o, 1);
      irq[6] = 1'b0; step(1);
      chk(int_o === 1'b0, "R8 request dropped", int_o, 0);
      do_ack(8'h47, "R8 spurious vector");
      irq[7] = 1'b1; step(1);
      chk(int_o === 1'b1, "R8 spurious sets no level", int_o, 1);
      do_ack(8'h47, "R8 real line 7");
      irq = '0; do_eoi(); step(1);

      // R9 and general: random traffic against the model
      for (int c = 0; c < 6000; c++) begin
         if ($urandom_range(3) == 0) irq = 16'($urandom & $urandom & $urandom);
         if ($urandom_range(40) == 0) mask = 16'($urandom & $urandom & $urandom);
         if ($urandom_range(100) == 0) begin
            base_m = 5'($urandom); base_s = 5'($urandom);
         end
         ack = ($urandom_range(5) == 0);
         eoi = ($urandom_range(5) == 0);
         step(1);
      end
      ack = 1'b0; eoi = 1'b0; irq = '0;
      step(2);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule